// File: doc/BRIEF.md
# Dual Cascadable Interval Timers

This block holds two 16-bit down-counters, timer A and timer B, each with its own 16-bit reload latch and an 8-bit control byte. Software reaches all of it through a byte-wide port: an address, a write strobe with write data, and a registered read-data output. Timer A counts cycles in which the count enable is high. Timer B counts either those same enabled cycles or the underflows of timer A, as its control byte selects.

When a running counter sits at zero and a count event arrives, it reloads from its latch and raises a one-cycle underflow pulse. Bit 0 of the underflow output belongs to timer A and bit 1 to timer B. A timer can free-run, reloading on every underflow, or it can run once and stop itself. The latch can be copied into the counter at any time by a strobe bit in the control byte. Writing the latch high byte also loads the counter, but only while the timer is stopped.

Top module: `cascade_timer_pair`

## Requirements
- R1: After reset both counters read 0xFFFF, both reload latches hold 0x0001, both control bytes read 0x00 and the underflow output is 0.
- R2: A write to a latch low-byte address (0 for A, 2 for B) changes only the latch low byte. The counter keeps its value.
- R3: A write to a latch high-byte address (1 for A, 3 for B) updates the latch high byte. It also loads the counter with the whole new latch value only when control bit 0 (run) is 0.
- R4: Writing a control byte (address 4 for A, 5 for B) with bit 4 set copies the latch into the counter. The control byte reads back as the written value AND 0xEF.
- R5: Timer A decrements by one in each cycle where tick_en is 1, its control bit 0 is 1 and its control bit 5 is 0. In every other case it holds its value.
- R6: Timer B decrements on tick_en cycles when its control bits {6,5,0} are 0,0,1. It decrements once per timer A underflow when they are 1,0,1. Any other value halts it. In cascade mode, tick_en alone does not move it.
- R7: A count event at a counter value of zero reloads the counter from its latch. It also sets that timer's underflow bit (bit 0 for A, bit 1 for B) for exactly one cycle. The bit rises at the same clock edge as the reload.
- R8: With control bit 3 (one-shot) set, an underflow clears control bit 0 after the reload. The counter then holds the latch value.
- R9: rd_data shows, one clock edge after the address is presented, the byte at that address as it stood before that edge. Address 0 is the A count low byte, 1 the A count high byte, 2 the B count low byte, 3 the B count high byte, 4 the A control byte and 5 the B control byte. Addresses 6 and 7 read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count enable for the system-tick source |
| wr_en | input | 1 | Write strobe |
| addr | input | 3 | Register address, used for both writes and reads |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| uf | output | 2 | Underflow pulses: bit 0 for timer A, bit 1 for timer B |

## Verification
Read data follows the address by one edge and shows the state from before that edge, so the bench samples rd_data 1 ns after the edge that follows the address. The underflow pulse and the counter reload land on that same edge. Counter updates from a write or a count event show up on the next read. The bench therefore counts one edge per event and checks pulses in the cycle where the counter passes through zero, and checks nothing earlier. The cascade case runs timer A with latch 1 for six enabled cycles, which makes timer A and timer B underflow on the same edge. A random phase then compares every cycle against a cycle model in the bench.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;
  localparam int ADDR_W      = 3;
  localparam int NUM_TMR     = 2;
  localparam int BIT_RUN     = 0;
  localparam int BIT_ONESHOT = 3;
  localparam int BIT_FORCE   = 4;
  localparam int BIT_EXTSRC  = 5;
  localparam int BIT_CASC    = 6;

  localparam logic [ADDR_W-1:0] ADR_A_LO  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_A_HI  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_B_LO  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_B_HI  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_A_CTL = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_B_CTL = 3'd5;

  function automatic logic [ADDR_W-1:0] lo_adr(input int idx);
    return ADDR_W'(2 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] hi_adr(input int idx);
    return ADDR_W'(2 * idx + 1);
  endfunction

  function automatic logic [ADDR_W-1:0] ctl_adr(input int idx);
    return ADDR_W'(2 * NUM_TMR + idx);
  endfunction
endpackage

// File: rtl/ctimer_src.sv
module ctimer_src
  import ctimer_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter bit CASCADE = 1'b0
) (
  input  logic [DATA_W-1:0] ctl,
  input  logic              tick_en,
  input  logic              casc_ev,
  output logic              cnt_ev
);
  generate
    if (CASCADE) begin : g_casc
      logic [2:0] mode;
      assign mode = {ctl[BIT_CASC], ctl[BIT_EXTSRC], ctl[BIT_RUN]};
      always_comb begin
        case (mode)
          3'b001:  cnt_ev = tick_en;
          3'b101:  cnt_ev = casc_ev;
          default: cnt_ev = 1'b0;
        endcase
      end
    end else begin : g_plain
      logic unused_src;
      assign unused_src = ^{casc_ev, ctl};
      assign cnt_ev = tick_en & ctl[BIT_RUN] & ~ctl[BIT_EXTSRC];
    end
  endgenerate
endmodule

// File: rtl/ctimer_unit.sv
module ctimer_unit
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_ctl,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cnt_ev,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  lat_q,
  output logic [DATA_W-1:0] ctl_q,
  output logic              uf_now,
  output logic              uf_q
);
  localparam logic [DATA_W-1:0] STORE_MASK = ~(DATA_W'(1) << BIT_FORCE);

  logic             load_req;
  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_req = 1'b0;
    load_val = lat_q;
    if (wr_ctl && wdata[BIT_FORCE]) begin
      load_req = 1'b1;
    end else if (wr_hi && !ctl_q[BIT_RUN]) begin
      load_req = 1'b1;
      load_val = {wdata, lat_q[DATA_W-1:0]};
    end
    uf_now = cnt_ev && (cnt_q == '0) && !load_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      lat_q <= CNT_W'(1);
      ctl_q <= '0;
      uf_q  <= 1'b0;
    end else begin
      uf_q <= uf_now;
      if (load_req)
        cnt_q <= load_val;
      else if (cnt_ev)
        cnt_q <= (cnt_q == '0) ? lat_q : cnt_q - CNT_W'(1);
      if (wr_lo) lat_q[DATA_W-1:0]     <= wdata;
      if (wr_hi) lat_q[CNT_W-1:DATA_W] <= wdata;
      if (wr_ctl)
        ctl_q <= wdata & STORE_MASK;
      else if (uf_now && ctl_q[BIT_ONESHOT])
        ctl_q[BIT_RUN] <= 1'b0;
    end
  end
endmodule

// File: rtl/ctimer_bus.sv
module ctimer_bus
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt  [NUM_TMR],
  input  logic [DATA_W-1:0] ctl  [NUM_TMR],
  output logic              wr_lo  [NUM_TMR],
  output logic              wr_hi  [NUM_TMR],
  output logic              wr_ctl [NUM_TMR],
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] rd_sel;

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_dec
      assign wr_lo[i]  = wr_en && (addr == lo_adr(i));
      assign wr_hi[i]  = wr_en && (addr == hi_adr(i));
      assign wr_ctl[i] = wr_en && (addr == ctl_adr(i));
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_TMR; i++) begin
      if (addr == lo_adr(i))  rd_sel = cnt[i][DATA_W-1:0];
      if (addr == hi_adr(i))  rd_sel = cnt[i][CNT_W-1:DATA_W];
      if (addr == ctl_adr(i)) rd_sel = ctl[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel;
  end
endmodule

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair
  import ctimer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_TMR-1:0] uf
);
  logic [CNT_W-1:0]  cnt    [NUM_TMR];
  logic [CNT_W-1:0]  lat    [NUM_TMR];
  logic [DATA_W-1:0] ctl    [NUM_TMR];
  logic              wr_lo  [NUM_TMR];
  logic              wr_hi  [NUM_TMR];
  logic              wr_ctl [NUM_TMR];
  logic [NUM_TMR-1:0] ev;
  logic [NUM_TMR-1:0] uf_now;
  logic [NUM_TMR-1:0] casc_in;

  ctimer_bus #(.DATA_W(DATA_W)) u_bus (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .cnt(cnt), .ctl(ctl),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_ctl(wr_ctl),
    .rd_data(rd_data)
  );

  generate
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      if (i == 0) begin : g_first
        assign casc_in[i] = 1'b0;
      end else begin : g_chain
        assign casc_in[i] = uf_now[i-1];
      end

      ctimer_src #(.DATA_W(DATA_W), .CASCADE(i > 0)) u_src (
        .ctl(ctl[i]), .tick_en(tick_en), .casc_ev(casc_in[i]), .cnt_ev(ev[i])
      );

      ctimer_unit #(.DATA_W(DATA_W)) u_unit (
        .clk(clk), .rst(rst),
        .wr_lo(wr_lo[i]), .wr_hi(wr_hi[i]), .wr_ctl(wr_ctl[i]),
        .wdata(wr_data), .cnt_ev(ev[i]),
        .cnt_q(cnt[i]), .lat_q(lat[i]), .ctl_q(ctl[i]),
        .uf_now(uf_now[i]), .uf_q(uf[i])
      );
    end
  endgenerate
endmodule

// File: rtl/ctimer_chk.sv
module ctimer_chk
  import ctimer_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [7:0]  wr_data,
  input logic [1:0]  uf,
  input logic [15:0] cnt_a,
  input logic [15:0] lat_a,
  input logic [7:0]  ctl_a,
  input logic        ev_a,
  input logic [15:0] cnt_b,
  input logic [7:0]  ctl_b
);
  AST_LOW_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_A_LO && !ev_a) |=> cnt_a == $past(cnt_a)); // R2

  AST_HIGH_WRITE_RUNNING: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_A_HI && ctl_a[0] && !ev_a) |=> cnt_a == $past(cnt_a)); // R3

  AST_FORCE_LOADS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_A_CTL && wr_data[4]) |=> cnt_a == $past(lat_a)); // R4

  AST_A_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!ctl_a[0] && !wr_en) |=> $stable(cnt_a)); // R5

  AST_B_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ({ctl_b[6], ctl_b[5], ctl_b[0]} != 3'b001 && {ctl_b[6], ctl_b[5], ctl_b[0]} != 3'b101
     && !wr_en) |=> $stable(cnt_b)); // R6

  AST_UF_RELOADS: assert property (@(posedge clk) disable iff (rst)
    uf[0] |-> cnt_a == $past(lat_a)); // R7

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (ev_a && cnt_a == 16'h0 && ctl_a[3] && !wr_en) |=> (!ctl_a[0] && uf[0])); // R8
endmodule

bind cascade_timer_pair ctimer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .uf(uf),
  .cnt_a(cnt[0]), .lat_a(lat[0]), .ctl_a(ctl[0]), .ev_a(ev[0]),
  .cnt_b(cnt[1]), .ctl_b(ctl[1])
);

// File: tb/cascade_timer_pair_tb.sv
module cascade_timer_pair_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [1:0] uf;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [15:0] m_cnt [2];
  logic [15:0] m_lat [2];
  logic [7:0]  m_ctl [2];
  logic [7:0]  exp_rd;
  logic [1:0]  exp_uf;
  logic [7:0]  got_rd;
  logic [1:0]  got_uf;

  always #2 clk = ~clk;

  cascade_timer_pair u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .uf(uf)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[0][7:0];
      3'd1: return m_cnt[0][15:8];
      3'd2: return m_cnt[1][7:0];
      3'd3: return m_cnt[1][15:8];
      3'd4: return m_ctl[0];
      3'd5: return m_ctl[1];
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_reset();
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = 16'hFFFF; m_lat[i] = 16'h0001; m_ctl[i] = 8'h00;
    end
    exp_uf = 2'b00;
  endtask

  task automatic m_step(input bit we, input logic [2:0] a, input logic [7:0] d, input bit tk);
    logic [15:0] nc [2];
    logic [15:0] nl [2];
    logic [7:0]  nt [2];
    bit ev [2];
    bit ld [2];
    bit u  [2];
    exp_rd = m_read(a);
    ev[0] = tk && m_ctl[0][0] && !m_ctl[0][5];
    for (int i = 0; i < 2; i++) begin
      nc[i] = m_cnt[i]; nl[i] = m_lat[i]; nt[i] = m_ctl[i];
      if (i == 1) begin
        ev[1] = ({m_ctl[1][6], m_ctl[1][5], m_ctl[1][0]} == 3'b001) ? tk :
                ({m_ctl[1][6], m_ctl[1][5], m_ctl[1][0]} == 3'b101) ? u[0] : 1'b0;
      end
      ld[i] = 1'b0;
      if (we && a == 3'(4 + i) && d[4]) begin ld[i] = 1; nc[i] = m_lat[i]; end
      else if (we && a == 3'(2 * i + 1) && !m_ctl[i][0]) begin
        ld[i] = 1; nc[i] = {d, m_lat[i][7:0]};
      end
      u[i] = ev[i] && m_cnt[i] == 16'h0 && !ld[i];
      if (!ld[i] && ev[i]) nc[i] = (m_cnt[i] == 16'h0) ? m_lat[i] : m_cnt[i] - 16'h1;
      if (we && a == 3'(2 * i))     nl[i][7:0]  = d;
      if (we && a == 3'(2 * i + 1)) nl[i][15:8] = d;
      if (we && a == 3'(4 + i)) nt[i] = d & 8'hEF;
      else if (u[i] && m_ctl[i][3]) nt[i][0] = 1'b0;
    end
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = nc[i]; m_lat[i] = nl[i]; m_ctl[i] = nt[i];
    end
    exp_uf = {u[1], u[0]};
  endtask

  task automatic step(input bit we, input logic [2:0] a, input logic [7:0] d, input bit tk);
    @(negedge clk);
    wr_en = we; addr = a; wr_data = d; tick_en = tk;
    m_step(we, a, d, tk);
    @(posedge clk);
    #1;
    got_rd = rd_data; got_uf = uf;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic rd(input logic [2:0] a);
    step(1'b0, a, 8'h00, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; tick_en = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    do_reset();
    #1;
    check("R1 uf after reset", uf, 2'b00);
    // R1 / R9: reset values through the read port
    rd(3'd0); check("R1 A cnt lo", got_rd, 8'hFF);
    rd(3'd1); check("R1 A cnt hi", got_rd, 8'hFF);
    rd(3'd2); check("R1 B cnt lo", got_rd, 8'hFF);
    rd(3'd3); check("R1 B cnt hi", got_rd, 8'hFF);
    rd(3'd4); check("R1 A ctl", got_rd, 8'h00);
    rd(3'd5); check("R1 B ctl", got_rd, 8'h00);
    rd(3'd6); check("R9 unused addr", got_rd, 8'h00);
    // R4: force load exposes the reset latch 0x0001
    wr(3'd4, 8'h10);
    rd(3'd0); check("R4 force lo", got_rd, 8'h01);
    rd(3'd1); check("R4 force hi", got_rd, 8'h00);
    rd(3'd4); check("R4 force bit not stored", got_rd, 8'h00);
    // R2: low latch write leaves counter alone
    wr(3'd0, 8'h34);
    rd(3'd0); check("R2 counter unchanged", got_rd, 8'h01);
    // R3: high write while stopped loads the full latch
    wr(3'd1, 8'h12);
    rd(3'd0); check("R3 load lo", got_rd, 8'h34);
    rd(3'd1); check("R3 load hi", got_rd, 8'h12);
    wr(3'd4, 8'h01);
    wr(3'd1, 8'h56);
    rd(3'd1); check("R3 running no load", got_rd, 8'h12);
    // R5: bit 5 halts timer A even with ticks
    wr(3'd4, 8'h21);
    for (int k = 0; k < 5; k++) step(1'b0, 3'd0, 8'h00, 1'b1);
    check("R5 halted by bit5", got_rd, 8'h34);
    rd(3'd4); check("R4 ctl readback", got_rd, 8'h21);
    // R7 / R8: one-shot from latch 3
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h00);
    wr(3'd4, 8'h19);
    step(1'b0, 3'd4, 8'h00, 1'b1);
    step(1'b0, 3'd0, 8'h00, 1'b1); check("R5 counting", got_rd, 8'h02);
    step(1'b0, 3'd4, 8'h00, 1'b1); check("R7 no early uf", got_uf, 2'b00);
    step(1'b0, 3'd4, 8'h00, 1'b1); check("R7 uf A pulse", got_uf, 2'b01);
    step(1'b0, 3'd4, 8'h00, 1'b1);
    check("R7 uf one cycle", got_uf, 2'b00);
    check("R8 run bit cleared", got_rd, 8'h08);
    rd(3'd0); check("R8 holds latch", got_rd, 8'h03);
    // R6: cascade B on A underflows
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h00);
    wr(3'd0, 8'h01);
    wr(3'd4, 8'h11);
    wr(3'd5, 8'h41);
    step(1'b0, 3'd2, 8'h00, 1'b1);
    step(1'b0, 3'd2, 8'h00, 1'b1); check("R6 cascade ignores ticks", got_rd, 8'h02);
    step(1'b0, 3'd2, 8'h00, 1'b1);
    step(1'b0, 3'd2, 8'h00, 1'b1); check("R7 A only uf", got_uf, 2'b01);
    step(1'b0, 3'd2, 8'h00, 1'b1); check("R6 B after two A uf", got_rd, 8'h00);
    step(1'b0, 3'd2, 8'h00, 1'b1); check("R6 joint uf", got_uf, 2'b11);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h01);
    step(1'b0, 3'd2, 8'h00, 1'b1);
    rd(3'd2); check("R6 B tick mode", got_rd, 8'h01);
    wr(3'd5, 8'h61);
    for (int k = 0; k < 3; k++) step(1'b0, 3'd2, 8'h00, 1'b1);
    rd(3'd2); check("R6 B halted", got_rd, 8'h01);
    // random phase against the bench model
    do_reset();
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] a;
      logic [7:0] d;
      bit we;
      bit tk;
      we = ($urandom % 4) == 0;
      a  = 3'($urandom % 8);
      tk = ($urandom % 8) != 0;
      d  = 8'($urandom);
      if (we && (a == 3'd1 || a == 3'd3) && ($urandom % 4) != 0) d = 8'h00;
      if (we && (a == 3'd0 || a == 3'd2)) d = d & 8'h07;
      step(we, a, d, tk);
      check("R9 random read", got_rd, exp_rd);
      check("R7 random uf", got_uf, exp_uf);
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule